// File: doc/BRIEF.md
# Three-Wire Serial Control Slave

This block is the device side of a three-wire control bus made of a data line, a mode line and a clock line. All three lines are oversampled in the system clock domain. A two-flop synchroniser feeds an edge detector. Bits are taken on rising bus-clock edges and assembled least significant bit first. The level of the mode line decides how a completed byte is used. With the mode line low, the byte is a device-select byte. With the mode line high, the byte belongs to a data phase. A select byte carries a 6-bit device identifier and a 2-bit operation field. The operation picks either write/prepare-read or read-back. The block holds a small bank of 16-bit registers, and the surrounding logic sees their contents in parallel.

The controller is one state machine with seven states:

| State | Meaning |
|---|---|
| SLEEP | After reset; waits for the wake-up pulse. |
| IDLE | Deselected. |
| SEL_WR | Selected for write or prepare-read. |
| SEL_RD | Selected for read-back. |
| WR_REG | Receiving data byte pairs for a write. |
| PREP_DONE | Prepare-read stored; later bytes are ignored. |
| RD_XMIT | Driving the read-back bytes. |

Its transitions:

| Transition | Cause |
|---|---|
| wake | The first bus-clock rise moves SLEEP to IDLE. |
| enter-address | The mode line falls while awake; the state becomes IDLE. |
| select | A completed select byte moves to SEL_WR, SEL_RD or IDLE. |
| direction | The first data byte in SEL_WR moves to WR_REG or PREP_DONE. |
| start-read | The mode line rises in SEL_RD; the state becomes RD_XMIT. |

Top module: `ctl3w_slave`

## Requirements
- R1: Bits are sampled on rising bus-clock edges. The first bit of each byte is its bit 0.
- R2: A select byte (mode low) is decoded as follows. Bits 7:2 must equal DEV_ID. Bits 1:0 = 2'b10 select write/prepare-read, and 2'b11 select read-back.
- R3: Operation codes 2'b00 and 2'b01, or a non-matching identifier, leave the block deselected. Later data-phase bytes then change no register, and the data output stays disabled.
- R4: The first data byte after a write/prepare-read select is decoded as follows. Bit 0 is the direction (0 = write, 1 = prepare-read), and bits 7:1 give the register address.
- R5: A write sends a low byte and then a high byte. The register is updated once the high byte completes. Further byte pairs in the same data phase go to the same register.
- R6: A write to an address at or above NUM_REGS changes no register.
- R7: A prepare-read stores the address. A later read-back first returns a header byte with the address in bits 7:1 and bit 0 = 0, then the low data byte, then the high data byte, repeating the data pair while clocks continue.
- R8: The header's bit 0 is 1 (invalid), and the data bytes are zero, if the stored address is out of range or no prepare-read has happened since reset. The header address field is zero if none has happened.
- R9: The data output is enabled only during a read-back data phase. It changes only after falling bus-clock edges (or at the start of the phase), so it is stable while the clock is high.
- R10: After reset, the first bus-clock pulse only wakes the block and is not taken as a data bit.
- R11: Any change of the mode line restarts the bit count. A partial byte is dropped without effect.
- R12: Reset clears all registers to zero and disables the data output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk_i | input | 1 | Bus clock line (asynchronous) |
| ser_mode_i | input | 1 | Bus mode line: low = select phase, high = data phase |
| ser_dat_i | input | 1 | Bus data line from the controller |
| ser_dat_o | output | 1 | Read-back data toward the controller |
| ser_dat_oe | output | 1 | Enable for ser_dat_o |
| regs_o | output | NUM_REGS*16 | Register bank contents, register k at bits 16k+15:16k |

## Verification
The hardest situations to reach are the partial bytes: a few bits clocked in just before the mode line flips. Only a misaligned byte later on shows whether the bit count was properly restarted. The bench clocks four stray bits in the select phase, flips the mode twice, and then issues a full write. The write lands in the right register only if the count was reset. A second test leaves half a high byte pending when the select phase returns, and checks that the register did not change. The wake-up pulse is reached by issuing a select byte straight after reset. Its first bit is swallowed, so the following write must be ignored.

// File: rtl/ctl3w_pkg.sv
package ctl3w_pkg;
    typedef enum logic [2:0] {
        S_SLEEP,
        S_IDLE,
        S_SEL_WR,
        S_SEL_RD,
        S_WR_REG,
        S_PREP_DONE,
        S_RD_XMIT
    } ctl_state_t;

    localparam logic [1:0] OPM_WRITE = 2'b10;
    localparam logic [1:0] OPM_READ  = 2'b11;
    localparam int         BYTE_W    = 8;
    localparam int         REG_W     = 16;
endpackage

// File: rtl/ctl3w_sync.sv
module ctl3w_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_clk,
    input  logic bus_mode,
    input  logic bus_dat,
    output logic clk_rise,
    output logic clk_fall,
    output logic mode_lvl,
    output logic mode_chg,
    output logic dat_lvl
);
    localparam int TOP = STAGES - 1;

    logic [TOP:0] ck_p, md_p, dt_p;
    logic         ck_d, md_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ck_p <= '0;
            md_p <= '0;
            dt_p <= '0;
            ck_d <= 1'b0;
            md_d <= 1'b0;
        end else begin
            ck_p <= {ck_p[TOP-1:0], bus_clk};
            md_p <= {md_p[TOP-1:0], bus_mode};
            dt_p <= {dt_p[TOP-1:0], bus_dat};
            ck_d <= ck_p[TOP];
            md_d <= md_p[TOP];
        end
    end

    assign clk_rise = ck_p[TOP] & ~ck_d;
    assign clk_fall = ~ck_p[TOP] & ck_d;
    assign mode_lvl = md_p[TOP];
    assign mode_chg = md_p[TOP] ^ md_d;
    assign dat_lvl  = dt_p[TOP];
endmodule

// File: rtl/ctl3w_shift.sv
module ctl3w_shift (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_stb,
    input  logic       restart,
    input  logic       din,
    output logic       byte_done,
    output logic [7:0] byte_val,
    output logic [2:0] bit_cnt
);
    logic [6:0] sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr      <= '0;
            bit_cnt <= '0;
        end else if (restart) begin
            bit_cnt <= '0;
        end else if (bit_stb) begin
            sr      <= {din, sr[6:1]};
            bit_cnt <= bit_cnt + 3'd1;
        end
    end

    assign byte_done = bit_stb && !restart && (bit_cnt == 3'd7);
    assign byte_val  = {din, sr};

    // R11: a mode change always leaves the counter at bit 0
    p_restart_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (bit_cnt == 3'd0));
endmodule

// File: rtl/ctl3w_regs.sv
module ctl3w_regs #(
    parameter int NUM_REGS = 4,
    parameter int IDX_W    = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       wr_idx,
    input  logic [15:0]            wr_data,
    input  logic [IDX_W-1:0]       rd_idx,
    output logic [15:0]            rd_data,
    output logic [NUM_REGS*16-1:0] regs_flat
);
    logic [15:0] mem [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                mem[g] <= '0;
            else if (wr_en && wr_idx == IDX_W'(g))
                mem[g] <= wr_data;
        end
        assign regs_flat[g*16 +: 16] = mem[g];

        // R5: a strobed write lands in the addressed register
        p_write_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_idx == IDX_W'(g)) |=> (mem[g] == $past(wr_data)));
        // R6: without a strobe no register moves
        p_hold_without_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_en |=> $stable(mem[g]));
    end

    assign rd_data = mem[rd_idx];
endmodule

// File: rtl/ctl3w_slave.sv
module ctl3w_slave #(
    parameter logic [5:0] DEV_ID   = 6'h15,
    parameter int         NUM_REGS = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ser_clk_i,
    input  logic                   ser_mode_i,
    input  logic                   ser_dat_i,
    output logic                   ser_dat_o,
    output logic                   ser_dat_oe,
    output logic [NUM_REGS*16-1:0] regs_o
);
    import ctl3w_pkg::*;

    localparam int         IDX_W     = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
    localparam logic [6:0] REG_LIMIT = 7'(NUM_REGS);

    logic clk_rise, clk_fall, mode_lvl, mode_chg, dat_lvl;
    logic bit_stb, byte_done;
    logic [7:0] byte_val;
    logic [2:0] bit_cnt;

    ctl_state_t state, nxt;

    logic [6:0]  tgt_addr, prep_addr;
    logic        prep_seen, hi_phase, tx_hi, dat_oe;
    logic [7:0]  lo_hold, tx_sr;
    logic        wr_en, rd_ok;
    logic [15:0] rd_data;
    logic [7:0]  hdr_byte, rd_lo, rd_hi;

    logic addr_byte, data_byte, enter_addr, enter_data;

    ctl3w_sync #(.STAGES(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_clk  (ser_clk_i),
        .bus_mode (ser_mode_i),
        .bus_dat  (ser_dat_i),
        .clk_rise (clk_rise),
        .clk_fall (clk_fall),
        .mode_lvl (mode_lvl),
        .mode_chg (mode_chg),
        .dat_lvl  (dat_lvl)
    );

    assign bit_stb = clk_rise && (state != S_SLEEP);

    ctl3w_shift u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_stb   (bit_stb),
        .restart   (mode_chg),
        .din       (dat_lvl),
        .byte_done (byte_done),
        .byte_val  (byte_val),
        .bit_cnt   (bit_cnt)
    );

    assign addr_byte  = byte_done && !mode_lvl;
    assign data_byte  = byte_done && mode_lvl;
    assign enter_addr = mode_chg && !mode_lvl;
    assign enter_data = mode_chg && mode_lvl;

    function automatic ctl_state_t sel_of(input logic [7:0] b);
        if (b[7:2] != DEV_ID)     return S_IDLE;
        if (b[1:0] == OPM_WRITE)  return S_SEL_WR;
        if (b[1:0] == OPM_READ)   return S_SEL_RD;
        return S_IDLE;
    endfunction

    always_comb begin
        nxt = state;
        unique case (state)
            S_SLEEP:     if (clk_rise) nxt = S_IDLE;
            S_IDLE:      nxt = S_IDLE;
            S_SEL_WR:    if (data_byte) nxt = byte_val[0] ? S_PREP_DONE : S_WR_REG;
            S_SEL_RD:    if (enter_data) nxt = S_RD_XMIT;
            S_WR_REG:    nxt = S_WR_REG;
            S_PREP_DONE: nxt = S_PREP_DONE;
            S_RD_XMIT:   nxt = S_RD_XMIT;
            default:     nxt = S_IDLE;
        endcase
        if (state != S_SLEEP) begin
            if (enter_addr)
                nxt = S_IDLE;
            else if (addr_byte)
                nxt = sel_of(byte_val);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_SLEEP;
        else        state <= nxt;
    end

    assign rd_ok    = prep_seen && (prep_addr < REG_LIMIT);
    assign hdr_byte = {prep_addr, ~rd_ok};
    assign rd_lo    = rd_ok ? rd_data[7:0]  : 8'h00;
    assign rd_hi    = rd_ok ? rd_data[15:8] : 8'h00;
    assign wr_en    = (state == S_WR_REG) && data_byte && hi_phase && (tgt_addr < REG_LIMIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt_addr  <= '0;
            prep_addr <= '0;
            prep_seen <= 1'b0;
            hi_phase  <= 1'b0;
            lo_hold   <= '0;
            tx_sr     <= '0;
            tx_hi     <= 1'b0;
            dat_oe    <= 1'b0;
        end else begin
            dat_oe <= (nxt == S_RD_XMIT);
            unique case (state)
                S_SEL_WR: begin
                    if (data_byte) begin
                        tgt_addr <= byte_val[7:1];
                        hi_phase <= 1'b0;
                        if (byte_val[0]) begin
                            prep_addr <= byte_val[7:1];
                            prep_seen <= 1'b1;
                        end
                    end
                end
                S_WR_REG: begin
                    if (data_byte) begin
                        if (!hi_phase) lo_hold <= byte_val;
                        hi_phase <= !hi_phase;
                    end
                end
                S_SEL_RD: begin
                    if (enter_data) begin
                        tx_sr <= hdr_byte;
                        tx_hi <= 1'b0;
                    end
                end
                S_RD_XMIT: begin
                    if (clk_fall) begin
                        if (bit_cnt == 3'd0) begin
                            tx_sr <= tx_hi ? rd_hi : rd_lo;
                            tx_hi <= !tx_hi;
                        end else begin
                            tx_sr <= {1'b0, tx_sr[7:1]};
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    ctl3w_regs #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (tgt_addr[IDX_W-1:0]),
        .wr_data   ({byte_val, lo_hold}),
        .rd_idx    (prep_addr[IDX_W-1:0]),
        .rd_data   (rd_data),
        .regs_flat (regs_o)
    );

    assign ser_dat_oe = dat_oe;
    assign ser_dat_o  = dat_oe ? tx_sr[0] : 1'b0;

    // R9: leaving the data phase drops the driver on the next cycle
    p_oe_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_dat_oe && mode_chg) |=> !ser_dat_oe);
    // R9: the driven bit moves only after a falling bus-clock edge
    p_tx_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_dat_oe && $past(ser_dat_oe) && !$past(clk_fall)) |-> $stable(ser_dat_o));
    // R10: asleep, nothing is written and nothing is driven
    p_sleep_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SLEEP) |-> (!wr_en && !ser_dat_oe));
    // R3: an unused operation code deselects
    p_unused_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_byte && !byte_val[1]) |=> (state == S_IDLE));
endmodule

// File: tb/ctl3w_slave_test.sv
module ctl3w_slave_test;
    localparam logic [5:0] DEV  = 6'h15;
    localparam int         NR   = 4;
    localparam int         HALF = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk_i = 1'b0, ser_mode_i = 1'b0, ser_dat_i = 1'b0;
    logic ser_dat_o, ser_dat_oe;
    logic [NR*16-1:0] regs_o;

    int total = 0;
    int bad = 0;
    bit done = 0;
    logic [15:0] exp_regs [NR];

    always #5 clk = ~clk;

    ctl3w_slave #(.DEV_ID(DEV), .NUM_REGS(NR)) uut (
        .clk(clk), .rst_n(rst_n),
        .ser_clk_i(ser_clk_i), .ser_mode_i(ser_mode_i), .ser_dat_i(ser_dat_i),
        .ser_dat_o(ser_dat_o), .ser_dat_oe(ser_dat_oe), .regs_o(regs_o)
    );

    task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_bit(input logic b);
        ser_dat_i = b;
        wait_cyc(HALF);
        ser_clk_i = 1'b1;
        wait_cyc(HALF);
        ser_clk_i = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) bus_bit(v[i]);
    endtask

    task automatic set_mode(input logic m);
        wait_cyc(HALF);
        ser_mode_i = m;
        wait_cyc(HALF);
    endtask

    task automatic recv_byte(output logic [7:0] v, inout int moved);
        logic early;
        for (int i = 0; i < 8; i++) begin
            ser_dat_i = 1'b0;
            wait_cyc(HALF);
            ser_clk_i = 1'b1;
            wait_cyc(2);
            early = ser_dat_o;
            wait_cyc(HALF - 2);
            v[i] = ser_dat_o;
            if (early !== v[i]) moved++;
            ser_clk_i = 1'b0;
        end
    endtask

    task automatic check_regs(input string req);
        for (int r = 0; r < NR; r++) chk_eq(req, 32'(regs_o[r*16 +: 16]), 32'(exp_regs[r]));
    endtask

    task automatic wr_txn(input logic [5:0] id, input logic [1:0] opm, input logic [6:0] ra,
                          input logic [15:0] val);
        set_mode(1'b0);
        send_byte({id, opm});
        set_mode(1'b1);
        send_byte({ra, 1'b0});
        send_byte(val[7:0]);
        send_byte(val[15:8]);
        set_mode(1'b0);
        wait_cyc(4);
    endtask

    task automatic prep_txn(input logic [6:0] ra);
        set_mode(1'b0);
        send_byte({DEV, 2'b10});
        set_mode(1'b1);
        send_byte({ra, 1'b1});
        set_mode(1'b0);
        wait_cyc(4);
    endtask

    task automatic rd_txn(input string req, input logic [7:0] exp_hdr, input logic [15:0] exp_val);
        logic [7:0] b;
        int moved;
        moved = 0;
        set_mode(1'b0);
        send_byte({DEV, 2'b11});
        set_mode(1'b1);
        chk_eq({req, " R9 oe in read"}, 32'(ser_dat_oe), 32'd1);
        recv_byte(b, moved); chk_eq({req, " R7 header"}, 32'(b), 32'(exp_hdr));
        recv_byte(b, moved); chk_eq({req, " R7 low"},    32'(b), 32'(exp_val[7:0]));
        recv_byte(b, moved); chk_eq({req, " R7 high"},   32'(b), 32'(exp_val[15:8]));
        recv_byte(b, moved); chk_eq({req, " R7 low rpt"}, 32'(b), 32'(exp_val[7:0]));
        recv_byte(b, moved); chk_eq({req, " R7 high rpt"}, 32'(b), 32'(exp_val[15:8]));
        chk_eq({req, " R9 stable while high"}, 32'(moved), 32'd0);
        set_mode(1'b0);
        wait_cyc(4);
        chk_eq({req, " R9 oe off"}, 32'(ser_dat_oe), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int r = 0; r < NR; r++) exp_regs[r] = 16'h0000;
        wait_cyc(5);
        // R12: reset state
        check_regs("R12 reset regs");
        chk_eq("R12 reset oe", 32'(ser_dat_oe), 32'd0);
        rst_n = 1'b1;
        wait_cyc(5);

        // R10: the first pulse only wakes; the select byte is broken and the write ignored
        send_byte({DEV, 2'b10});
        set_mode(1'b1);
        send_byte({7'd0, 1'b0});
        send_byte(8'hFF);
        send_byte(8'hFF);
        set_mode(1'b0);
        wait_cyc(4);
        check_regs("R10 wake pulse swallowed");

        // R8: read-back before any prepare
        rd_txn("R8 no prepare", 8'h01, 16'h0000);

        // R1 R2 R4 R5: write each register with its own pattern
        for (int r = 0; r < NR; r++) begin
            logic [15:0] v;
            v = 16'h3C5A + 16'(r) * 16'h1357;
            wr_txn(DEV, 2'b10, 7'(r), v);
            exp_regs[r] = v;
        end
        check_regs("R1 R2 R4 R5 write sweep");

        // R5: two byte pairs in one data phase; the last one sticks
        set_mode(1'b0);
        send_byte({DEV, 2'b10});
        set_mode(1'b1);
        send_byte({7'd1, 1'b0});
        send_byte(8'h11); send_byte(8'h22);
        send_byte(8'h33); send_byte(8'h44);
        set_mode(1'b0);
        wait_cyc(4);
        exp_regs[1] = 16'h4433;
        check_regs("R5 repeated pairs");

        // R6: out-of-range writes
        wr_txn(DEV, 2'b10, 7'(NR), 16'hDEAD);
        wr_txn(DEV, 2'b10, 7'h7F, 16'hBEEF);
        check_regs("R6 out of range");

        // R3: unused codes and a foreign identifier
        wr_txn(DEV, 2'b00, 7'd0, 16'h0BAD);
        wr_txn(DEV, 2'b01, 7'd0, 16'h0BAD);
        wr_txn(DEV ^ 6'h01, 2'b10, 7'd0, 16'h0BAD);
        check_regs("R3 deselected writes");
        set_mode(1'b0);
        send_byte({DEV ^ 6'h20, 2'b11});
        set_mode(1'b1);
        chk_eq("R3 foreign read oe", 32'(ser_dat_oe), 32'd0);
        set_mode(1'b0);

        // R7 R9: prepare and read back every register
        for (int r = 0; r < NR; r++) begin
            prep_txn(7'(r));
            rd_txn("R7 readback", {7'(r), 1'b0}, exp_regs[r]);
        end

        // R8: prepare an address outside the bank
        prep_txn(7'd100);
        rd_txn("R8 out of range", {7'd100, 1'b1}, 16'h0000);

        // R11: stray bits before the select byte must not misalign it
        set_mode(1'b0);
        for (int i = 0; i < 4; i++) bus_bit(1'b1);
        set_mode(1'b1);
        set_mode(1'b0);
        send_byte({DEV, 2'b10});
        set_mode(1'b1);
        send_byte({7'd2, 1'b0});
        send_byte(8'h5E); send_byte(8'hA7);
        set_mode(1'b0);
        wait_cyc(4);
        exp_regs[2] = 16'hA75E;
        check_regs("R11 realign after stray bits");

        // R11: half a high byte when the mode drops leaves the register alone
        set_mode(1'b0);
        send_byte({DEV, 2'b10});
        set_mode(1'b1);
        send_byte({7'd3, 1'b0});
        send_byte(8'h99);
        for (int i = 0; i < 4; i++) bus_bit(1'b1);
        set_mode(1'b0);
        wait_cyc(4);
        check_regs("R11 partial byte dropped");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule